// File: doc/BRIEF.md
# Masked Interrupt Source Register

This block gathers single-cycle event pulses from a network controller into a sticky source register and gates them with a mask register to produce one level-sensitive interrupt request. The default build has three event bits: bit 0 marks a finished transmit buffer, bit 2 marks a filled receive buffer, and bit 4 marks a frame that arrived when no receive buffer was free. Which positions exist is set by a parameter.

A simple strobe port lets a host read either register, load the mask, and acknowledge events by writing ones to the source register. Acknowledgement and new events can meet in the same cycle. In that case the new event is kept, so no event is lost. The interrupt line is registered. It follows the masked source one clock after the register change that causes it, whether that change comes from an event, an acknowledgement or a mask update.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset, the source register and the mask register both read 0 and `irq_o` is low.
- R2: An event pulse on an implemented bit of `evt_set_i` sets that source bit at the next clock edge. Implemented bits by default: 0 (transmit done), 2 (receive done), 4 (busy).
- R3: Source bits are sticky. They hold while no acknowledgement hits them, and further events only add bits.
- R4: A host write with `host_sel_i`=0 (source) clears every source bit written as 1 and leaves bits written as 0 unchanged. Such a write never sets a bit.
- R5: When an event and an acknowledgement hit the same bit in the same cycle, the bit ends up set.
- R6: Source bit positions that are not implemented always read as 0, whatever events or writes arrive.
- R7: A host write with `host_sel_i`=1 (mask) loads all bits of the mask from `host_wdata_i`. A read with that select returns the stored value.
- R8: `irq_o` is high exactly when (source AND mask) is nonzero, and it lags the register contents by one clock.
- R9: Unmasking a pending source raises `irq_o` without any new event, and masking it again lowers the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_set_i | input | SRC_W | Event pulses, one per source bit |
| host_wr_i | input | 1 | Host write strobe |
| host_sel_i | input | 1 | Register select: 0 source, 1 mask |
| host_wdata_i | input | SRC_W | Host write data |
| host_rdata_o | output | SRC_W | Read data of the selected register |
| irq_o | output | 1 | Registered level interrupt request |

## Verification
The bench builds the block with its defaults: 8-bit registers, with bits 0, 2 and 4 implemented. At that width every event word, every acknowledgement word and every mask value can be applied, 256 each. For each event word, the expected source value comes from AND with the implemented set. Every mask is swept against all eight patterns of pending sources, and the interrupt is predicted from the AND of the two. The one-clock lag of the line is checked explicitly, as are simultaneous event and acknowledgement on every event word.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  typedef enum logic {
    SEL_SRC  = 1'b0,
    SEL_MASK = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/evt_irq_src_reg.sv
module evt_irq_src_reg #(
  parameter int unsigned SRC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] set_i,
  input  logic [SRC_W-1:0] clr_i,
  output logic [SRC_W-1:0] src_o
);
  logic [SRC_W-1:0] src_q;
  logic [SRC_W-1:0] src_d;
  logic [SRC_W-1:0] src_en;

  for (genvar i = 0; i < SRC_W; i++) begin : g_bit
    always_comb begin
      src_en[i] = set_i[i] | clr_i[i];
      src_d[i]  = set_i[i] | (src_q[i] & ~clr_i[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_q[i] <= 1'b0;
      end else if (src_en[i]) begin
        src_q[i] <= src_d[i];
      end
    end

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> src_q[i]);
    // R4
    clr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !src_q[i]);
    // R3
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_q[i] && !clr_i[i]) |=> src_q[i]);
  end

  assign src_o = src_q;
endmodule

// File: rtl/evt_irq_mask_reg.sv
module evt_irq_mask_reg #(
  parameter int unsigned SRC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [SRC_W-1:0] wdata_i,
  output logic [SRC_W-1:0] mask_o
);
  logic [SRC_W-1:0] mask_q;
  logic [SRC_W-1:0] mask_d;

  always_comb begin
    mask_d = mask_q;
    if (wr_i) mask_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (wr_i) begin
      mask_q <= mask_d;
    end
  end

  // R7
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (mask_q == $past(wdata_i)));

  assign mask_o = mask_q;
endmodule

// File: rtl/evt_irq_out.sv
module evt_irq_out #(
  parameter int unsigned SRC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] src_i,
  input  logic [SRC_W-1:0] mask_i,
  output logic             irq_o
);
  logic irq_q;
  logic irq_d;

  always_comb begin
    irq_d = |(src_i & mask_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl #(
  parameter int unsigned     SRC_W     = 8,
  parameter logic [SRC_W-1:0] IMPL_BITS = 8'h15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] evt_set_i,
  input  logic             host_wr_i,
  input  logic             host_sel_i,
  input  logic [SRC_W-1:0] host_wdata_i,
  output logic [SRC_W-1:0] host_rdata_o,
  output logic             irq_o
);
  import evt_irq_pkg::*;

  reg_sel_e         sel;
  logic [SRC_W-1:0] set_v;
  logic [SRC_W-1:0] clr_v;
  logic             mask_wr;
  logic [SRC_W-1:0] src_q;
  logic [SRC_W-1:0] mask_q;

  always_comb begin
    sel     = reg_sel_e'(host_sel_i);
    set_v   = evt_set_i & IMPL_BITS;
    clr_v   = (host_wr_i && sel == SEL_SRC) ? (host_wdata_i & IMPL_BITS) : '0;
    mask_wr = host_wr_i && sel == SEL_MASK;
  end

  evt_irq_src_reg #(.SRC_W(SRC_W)) u_src (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (set_v),
    .clr_i (clr_v),
    .src_o (src_q)
  );

  evt_irq_mask_reg #(.SRC_W(SRC_W)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (mask_wr),
    .wdata_i (host_wdata_i),
    .mask_o  (mask_q)
  );

  evt_irq_out #(.SRC_W(SRC_W)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_i  (src_q),
    .mask_i (mask_q),
    .irq_o  (irq_o)
  );

  always_comb begin
    host_rdata_o = (sel == SEL_MASK) ? mask_q : src_q;
  end

  // R6
  undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel_i == 1'b0) |-> ((host_rdata_o & ~IMPL_BITS) == '0));
  // R9
  unmask_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && (src_q & host_wdata_i) != '0) |=> ##1 irq_o);
  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_q & mask_q) == '0) |=> !irq_o);
endmodule

// File: tb/evt_irq_ctrl_bench.sv
module evt_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] IMPL = 8'h15;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] evt;
  logic       host_wr;
  logic       host_sel;
  logic [7:0] host_wdata;
  logic [7:0] host_rdata;
  logic       irq;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_irq_ctrl u_evt_irq_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_set_i    (evt),
    .host_wr_i    (host_wr),
    .host_sel_i   (host_sel),
    .host_wdata_i (host_wdata),
    .host_rdata_o (host_rdata),
    .irq_o        (irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic s, output logic [7:0] d);
    @(negedge clk);
    host_sel = s;
    #1 d = host_rdata;
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_sel = s; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0; host_wdata = '0;
  endtask

  task automatic pulse(input logic [7:0] v);
    @(negedge clk);
    evt = v;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic pulse_and_clear(input logic [7:0] v, input logic [7:0] c);
    @(negedge clk);
    evt = v; host_wr = 1'b1; host_sel = 1'b0; host_wdata = c;
    @(negedge clk);
    evt = '0; host_wr = 1'b0; host_wdata = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] sp;
    rst_n = 1'b0; evt = '0; host_wr = 1'b0; host_sel = 1'b0; host_wdata = '0;
    repeat (3) @(negedge clk);
    rd(1'b0, d); chk("R1 source after reset", d, 8'h00);
    rd(1'b1, d); chk("R1 mask after reset", d, 8'h00);
    chk("R1 irq after reset", {7'b0, irq}, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    // R2 and R6: every event word
    for (int v = 0; v < 256; v++) begin
      pulse(v[7:0]);
      rd(1'b0, d); chk("R2/R6 event sets implemented bits", d, v[7:0] & IMPL);
      wr(1'b0, 8'hFF);
    end

    // R3: sticky accumulation
    pulse(8'h01);
    repeat (5) @(negedge clk);
    rd(1'b0, d); chk("R3 bit held", d, 8'h01);
    pulse(8'h04);
    rd(1'b0, d); chk("R3 bits accumulate", d, 8'h05);
    wr(1'b0, 8'h00);
    rd(1'b0, d); chk("R3 zero write keeps bits", d, 8'h05);
    wr(1'b0, 8'hFF);

    // R4: every acknowledgement word
    for (int c = 0; c < 256; c++) begin
      pulse(IMPL);
      wr(1'b0, c[7:0]);
      rd(1'b0, d); chk("R4 write-one clears", d, IMPL & ~c[7:0]);
      wr(1'b0, 8'hFF);
    end

    // R5: event and clear together on every event word
    for (int v = 0; v < 256; v++) begin
      pulse(IMPL);
      pulse_and_clear(v[7:0], 8'hFF);
      rd(1'b0, d); chk("R5 set wins over clear", d, v[7:0] & IMPL);
      wr(1'b0, 8'hFF);
    end

    // R8: one-clock lag of the line
    pulse(8'h01);
    wr(1'b1, 8'h01);
    chk("R8 irq not yet raised", {7'b0, irq}, 8'h00);
    @(negedge clk);
    chk("R8 irq raised one clock later", {7'b0, irq}, 8'h01);
    wr(1'b0, 8'h01);
    @(negedge clk);
    chk("R8 irq drops after clear", {7'b0, irq}, 8'h00);

    // R7, R8, R9: every mask against every pending pattern
    for (int s = 0; s < 8; s++) begin
      sp = (s[0] ? 8'h01 : 8'h00) | (s[1] ? 8'h04 : 8'h00) | (s[2] ? 8'h10 : 8'h00);
      wr(1'b0, 8'hFF);
      pulse(sp);
      for (int m = 0; m < 256; m++) begin
        wr(1'b1, m[7:0]);
        @(negedge clk);
        chk("R9 irq from mask update", {7'b0, irq}, {7'b0, (sp & m[7:0]) != 8'h00});
        rd(1'b1, d); chk("R7 mask readback", d, m[7:0]);
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule